// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational unit sits in front of a single-precision fused multiply-add datapath that computes z + x*y, or z - x*y when the negate-product control is high. It decodes the three raw 32-bit operand words into classes: zero, denormal, normal, infinity, quiet NaN and signaling NaN. It then decides whether the special operands alone fix the result.

When they do, it raises `bypass_o` and drives the finished 32-bit word on `result_o`, together with the invalid-operation flag. When the result needs real arithmetic, `bypass_o` is low, `result_o` and `invalid_o` are zero, and the downstream multiplier, adder and rounder produce the answer. Denormal operands are treated as finite nonzero values and are never flushed.

The rounding-mode input uses this encoding: 2'b00 round to nearest even, 2'b01 toward zero, 2'b10 toward plus infinity, 2'b11 toward minus infinity.

Top module: `fma_special_resolve`

## Requirements
- R1: Operand decode uses bits [30:23] as the exponent and bits [22:0] as the fraction. An all-ones exponent with a zero fraction is infinity. An all-ones exponent with a nonzero fraction is a NaN, quiet when bit 22 is set and signaling otherwise. A zero exponent with a zero fraction is zero, and a zero exponent with a nonzero fraction is a finite nonzero denormal.
- R2: If any operand is a signaling NaN, the first one in the order z, x, y is selected, even when quiet NaNs are also present. The result is that word with bit 22 set and all other bits unchanged, and `invalid_o` is 1.
- R3: With no signaling NaN present, the first quiet NaN in the order z, x, y is returned bit-for-bit, and `invalid_o` is 0.
- R4: With no NaN present, infinity times zero in either operand order returns 0x7FC00000 with `invalid_o` = 1.
- R5: Define the effective product sign as sign(x) XOR sign(y) XOR the negate control. If the product is infinite and z is an infinity whose sign differs from the effective product sign, the result is 0x7FC00000 with `invalid_o` = 1.
- R6: If the product is infinite and R5 does not apply, the result is an infinity (0x7F800000 or 0xFF800000) carrying the effective product sign, with `invalid_o` = 0.
- R7: If the product is zero and z is infinite or nonzero finite, the result is z unchanged, with `invalid_o` = 0.
- R8: If the product is zero and z is zero, the result is z when z's sign equals the effective product sign. Otherwise the result is a zero whose sign is 1 only when the rounding mode is 2'b11. `invalid_o` is 0 in both cases.
- R9: If the product is finite and nonzero and z is infinite, the result is z unchanged, with `invalid_o` = 0.
- R10: `bypass_o` is 0 exactly when no operand is a NaN or infinity, neither x nor y is zero, and z is not infinite. In that case `result_o` and `invalid_o` are 0. In every other case `bypass_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z_i | input | 32 | Addend operand word |
| op_x_i | input | 32 | First multiplicand word |
| op_y_i | input | 32 | Second multiplicand word |
| neg_prod_i | input | 1 | Subtract the product instead of adding it |
| rnd_mode_i | input | 2 | Rounding mode, encoded as in the description |
| bypass_o | output | 1 | Result is fixed by special operands |
| result_o | output | 32 | Resolved result word, zero when not bypassing |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The checker evaluates every input change. It confirms that any signaling NaN yields a quieted NaN with the flag raised (R2), and that a quiet NaN alone passes one of the input words through without the flag (R3). It also checks that infinity times zero gives the default NaN (R4), that an infinite product carries the effective sign (R6), that the zero-plus-zero sign follows the rounding mode (R8), and that the non-bypass case is clean (R10).

Only the bench's directed scenarios show the exact z-before-x-before-y selection when several NaNs compete, and the cancellation of opposite infinities under each setting of the negate control. The same holds for the pass-through of z when the product is zero or finite, and for denormals being treated as nonzero.

// File: rtl/fma_special_resolve.sv
module fma_special_resolve #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_z_i,
  input  logic [W-1:0] op_x_i,
  input  logic [W-1:0] op_y_i,
  input  logic         neg_prod_i,
  input  logic [1:0]   rnd_mode_i,
  output logic         bypass_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);

  localparam logic [1:0]   RND_DOWN = 2'b11;
  localparam logic [W-1:0] QBIT     = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] INF_MAG  = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DEF_NAN  = INF_MAG | QBIT;

  logic [W-1:0] ops [3];
  logic [2:0] snan, qnan, inf, zero, sgn;

  assign ops[0] = op_z_i;
  assign ops[1] = op_x_i;
  assign ops[2] = op_y_i;

  for (genvar i = 0; i < 3; i++) begin : g_cls
    logic e_ones, e_zero, f_zero;
    assign e_ones  = &ops[i][W-2:FRAC_W];
    assign e_zero  = ~|ops[i][W-2:FRAC_W];
    assign f_zero  = ~|ops[i][FRAC_W-1:0];
    assign snan[i] = e_ones & ~f_zero & ~ops[i][FRAC_W-1];
    assign qnan[i] = e_ones & ~f_zero &  ops[i][FRAC_W-1];
    assign inf[i]  = e_ones & f_zero;
    assign zero[i] = e_zero & f_zero;
    assign sgn[i]  = ops[i][W-1];
  end

  logic eff_sgn, prod_inf, prod_zero, inf_x_zero;
  assign eff_sgn    = sgn[1] ^ sgn[2] ^ neg_prod_i;
  assign inf_x_zero = (inf[1] & zero[2]) | (zero[1] & inf[2]);
  assign prod_inf   = inf[1] | inf[2];
  assign prod_zero  = zero[1] | zero[2];

  always_comb begin
    bypass_o  = 1'b1;
    invalid_o = 1'b0;
    result_o  = '0;
    if (|snan) begin
      invalid_o = 1'b1;
      if (snan[0])      result_o = op_z_i | QBIT;
      else if (snan[1]) result_o = op_x_i | QBIT;
      else              result_o = op_y_i | QBIT;
    end else if (|qnan) begin
      if (qnan[0])      result_o = op_z_i;
      else if (qnan[1]) result_o = op_x_i;
      else              result_o = op_y_i;
    end else if (inf_x_zero) begin
      invalid_o = 1'b1;
      result_o  = DEF_NAN;
    end else if (prod_inf) begin
      if (inf[0] && sgn[0] != eff_sgn) begin
        invalid_o = 1'b1;
        result_o  = DEF_NAN;
      end else begin
        result_o = INF_MAG | {eff_sgn, {(W-1){1'b0}}};
      end
    end else if (prod_zero) begin
      if (zero[0] && sgn[0] != eff_sgn)
        result_o = {rnd_mode_i == RND_DOWN, {(W-1){1'b0}}};
      else
        result_o = op_z_i;
    end else if (inf[0]) begin
      result_o = op_z_i;
    end else begin
      bypass_o = 1'b0;
    end
  end

endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic [W-1:0] op_z_i,
  input logic [W-1:0] op_x_i,
  input logic [W-1:0] op_y_i,
  input logic         neg_prod_i,
  input logic [1:0]   rnd_mode_i,
  input logic         bypass_o,
  input logic [W-1:0] result_o,
  input logic         invalid_o
);

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
  endfunction
  function automatic logic is_inf(input logic [W-1:0] v);
    return (&v[W-2:FRAC_W]) && !(|v[FRAC_W-1:0]);
  endfunction
  function automatic logic is_zero(input logic [W-1:0] v);
    return v[W-2:0] == '0;
  endfunction
  function automatic logic is_snan(input logic [W-1:0] v);
    return is_nan(v) && !v[FRAC_W-1];
  endfunction

  logic any_snan, any_nan, any_inf;
  assign any_snan = is_snan(op_z_i) | is_snan(op_x_i) | is_snan(op_y_i);
  assign any_nan  = is_nan(op_z_i) | is_nan(op_x_i) | is_nan(op_y_i);
  assign any_inf  = is_inf(op_z_i) | is_inf(op_x_i) | is_inf(op_y_i);

  always_comb begin
    if (any_snan)
      p_snan_quieted_r2: assert (bypass_o && invalid_o && is_nan(result_o) && result_o[FRAC_W-1]);
    if (any_nan && !any_snan)
      p_qnan_passthru_r3: assert (bypass_o && !invalid_o &&
        (result_o == op_z_i || result_o == op_x_i || result_o == op_y_i));
    if (!any_nan && ((is_inf(op_x_i) && is_zero(op_y_i)) || (is_zero(op_x_i) && is_inf(op_y_i))))
      p_inf_times_zero_r4: assert (invalid_o && result_o == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}});
    if (!any_nan && !invalid_o && (is_inf(op_x_i) || is_inf(op_y_i)))
      p_inf_prod_sign_r6: assert (is_inf(result_o) &&
        result_o[W-1] == (op_x_i[W-1] ^ op_y_i[W-1] ^ neg_prod_i));
    if (!any_nan && !any_inf && (is_zero(op_x_i) || is_zero(op_y_i)) && is_zero(op_z_i) &&
        op_z_i[W-1] != (op_x_i[W-1] ^ op_y_i[W-1] ^ neg_prod_i))
      p_zero_sum_sign_r8: assert (is_zero(result_o) && result_o[W-1] == (rnd_mode_i == 2'b11));
    if (!bypass_o)
      p_datapath_clean_r10: assert (!invalid_o && result_o == '0 && !any_nan && !any_inf &&
        !is_zero(op_x_i) && !is_zero(op_y_i));
  end

endmodule

bind fma_special_resolve fma_special_resolve_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_z_i(op_z_i), .op_x_i(op_x_i), .op_y_i(op_y_i),
  .neg_prod_i(neg_prod_i), .rnd_mode_i(rnd_mode_i),
  .bypass_o(bypass_o), .result_o(result_o), .invalid_o(invalid_o)
);

// File: tb/fma_special_resolve_tb.sv
module fma_special_resolve_tb;

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, THREE = 32'h4040_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] DNAN = 32'h7FC0_0000, DEN = 32'h0000_0001;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] z, x, y, res;
  logic neg, byp, inv;
  logic [1:0] rm;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  fma_special_resolve u_dut (
    .op_z_i(z), .op_x_i(x), .op_y_i(y), .neg_prod_i(neg), .rnd_mode_i(rm),
    .bypass_o(byp), .result_o(res), .invalid_o(inv)
  );

  task automatic apply(input logic [31:0] zz, xx, yy, input logic n, input logic [1:0] r);
    @(negedge clk);
    z = zz; x = xx; y = yy; neg = n; rm = r;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic eb, input logic ei);
    checks++;
    if (res !== er || byp !== eb || inv !== ei) begin
      errors++;
      $display("FAIL %s: got res=%h byp=%b inv=%b expected res=%h byp=%b inv=%b",
               tag, res, byp, inv, er, eb, ei);
    end
  endtask

  task automatic t_idle;
    apply(PZ, PZ, PZ, 1'b0, 2'b00); check("R8 all-zero start", PZ, 1, 0);
  endtask

  task automatic t_decode;
    apply(ONE, 32'h7F80_0001, ONE, 1'b0, 2'b00); check("R1 snan decode", 32'h7FC0_0001, 1, 1);
    apply(ONE, 32'h7FC0_0000, ONE, 1'b0, 2'b00); check("R1 qnan decode", DNAN, 1, 0);
    apply(ONE, DEN, DEN, 1'b0, 2'b00);          check("R1 denormal is nonzero", PZ, 0, 0);
  endtask

  task automatic t_snan;
    apply(32'h7FC0_0001, 32'h7F80_0005, 32'hFF81_2345, 1'b0, 2'b00);
    check("R2 snan beats qnan in z", 32'h7FC0_0005, 1, 1);
    apply(ONE, 32'hFF81_2345, 32'h7F80_0005, 1'b0, 2'b00);
    check("R2 x before y", 32'hFFC1_2345, 1, 1);
    apply(32'h7F80_0007, 32'h7F80_0005, ONE, 1'b1, 2'b11);
    check("R2 z first", 32'h7FC0_0007, 1, 1);
  endtask

  task automatic t_qnan;
    apply(ONE, 32'h7FC0_0001, 32'h7FC0_0099, 1'b0, 2'b00); check("R3 x before y", 32'h7FC0_0001, 1, 0);
    apply(32'hFFC0_0007, 32'h7FC0_0001, PINF, 1'b0, 2'b00); check("R3 z first", 32'hFFC0_0007, 1, 0);
    apply(ONE, PINF, 32'hFFC0_0003, 1'b0, 2'b00);          check("R3 y qnan over inf", 32'hFFC0_0003, 1, 0);
  endtask

  task automatic t_inf_zero;
    apply(ONE, PINF, NZ, 1'b0, 2'b00);  check("R4 inf*0", DNAN, 1, 1);
    apply(NINF, PZ, NINF, 1'b1, 2'b00); check("R4 0*inf", DNAN, 1, 1);
  endtask

  task automatic t_inf_prod;
    apply(NINF, PINF, TWO, 1'b0, 2'b00); check("R5 add opposite inf", DNAN, 1, 1);
    apply(PINF, PINF, TWO, 1'b1, 2'b00); check("R5 sub same inf", DNAN, 1, 1);
    apply(NINF, PINF, TWO, 1'b1, 2'b00); check("R6 sub matching inf", NINF, 1, 0);
    apply(PINF, PINF, TWO, 1'b0, 2'b00); check("R6 add matching inf", PINF, 1, 0);
    apply(ONE, NINF, TWO, 1'b1, 2'b00);  check("R6 negated sign", PINF, 1, 0);
    apply(ONE, NINF, PINF, 1'b0, 2'b00); check("R6 inf*inf", NINF, 1, 0);
  endtask

  task automatic t_zero_prod;
    apply(NINF, PZ, ONE, 1'b0, 2'b00);  check("R7 z inf", NINF, 1, 0);
    apply(THREE, ONE, NZ, 1'b1, 2'b00); check("R7 z finite", THREE, 1, 0);
    apply(PZ, PZ, ONE, 1'b0, 2'b11);    check("R8 same sign keep z", PZ, 1, 0);
    apply(NZ, PZ, ONE, 1'b0, 2'b00);    check("R8 differ nearest", PZ, 1, 0);
    apply(NZ, PZ, ONE, 1'b0, 2'b11);    check("R8 differ down", NZ, 1, 0);
    apply(NZ, PZ, ONE, 1'b1, 2'b10);    check("R8 negated match", NZ, 1, 0);
    apply(PZ, PZ, ONE, 1'b1, 2'b11);    check("R8 negated differ down", NZ, 1, 0);
    apply(PZ, PZ, ONE, 1'b1, 2'b01);    check("R8 negated differ zero-mode", PZ, 1, 0);
  endtask

  task automatic t_finite_prod;
    apply(NINF, ONE, DEN, 1'b0, 2'b00); check("R9 z inf", NINF, 1, 0);
    apply(PINF, NZ ^ TWO, TWO, 1'b1, 2'b00); check("R9 z inf negated", PINF, 1, 0);
    apply(ONE, ONE, TWO, 1'b0, 2'b00);  check("R10 datapath", PZ, 0, 0);
    apply(PZ, THREE, ONE, 1'b1, 2'b11); check("R10 zero z datapath", PZ, 0, 0);
  endtask

  initial begin
    z = '0; x = '0; y = '0; neg = 1'b0; rm = 2'b00;
    t_idle(); t_decode(); t_snan(); t_qnan(); t_inf_zero();
    t_inf_prod(); t_zero_prod(); t_finite_prod();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule